// File: doc/BRIEF.md
# Field Parity Detector

This block decides, once per field, whether the incoming video field is odd or even. It measures each line with a counter that restarts on every horizontal sync falling edge and derives a detection window from that count. When vertical sync ends (its rising edge, since both syncs are active-low), the block samples the window. A high window marks the field odd, and a low window marks it even. The result appears on a held flag, and a one-cycle strobe marks each update.

The same module serves both video paths, with one instance per path. The inset path runs at 12 MHz and always uses the half-line window. The main path runs at 18 MHz and also has a second window mode, selected when the measured horizontal sync high time reaches a threshold (1024 clocks by default). In that mode the window is the first half of the sync high interval, timed from the sync rising edge.

The block rejects a vertical sync pulse that is shorter than one line. It also rejects trailing edges that arrive before a valid line length is known, including after a line too long for the counter. Detection is reliable only when the trailing edge lands well inside the window, away from its edges.

Top module: `field_parity_det`

## Requirements
- R1: After reset, `field_odd_o` and `field_vld_o` are both 0.
- R2: Both sync inputs pass through a `SYNC_STAGES`-deep synchroniser (default 2). `field_vld_o` rises on the third rising clock edge after `vs_ni` rises and lasts exactly one cycle.
- R3: Half-line mode. Let P be the last measured line length, in clocks between two horizontal sync falling edges. Let d be the number of clocks from the `hs_ni` fall to the `vs_ni` rise, with 1 <= d <= P-1. The accepted field is odd (`field_odd_o` = 1) when d <= floor(P/2), and even (0) otherwise.
- R4: Sync-high mode applies only when `WIDE_EN` = 1 and the last measured high time H of `hs_ni` is at least `WIDE_THR` clocks. The field is odd when `vs_ni` rises while `hs_ni` is high and e clocks after its rising edge, with 1 <= e <= floor(H/2). Otherwise it is even.
- R5: With `WIDE_EN` = 0 the block always uses half-line mode, whatever the sync high time.
- R6: A `vs_ni` low pulse of L clocks is accepted only if L >= P. A shorter pulse produces no strobe and leaves `field_odd_o` unchanged.
- R7: No strobe is produced until two `hs_ni` falling edges have been seen after reset.
- R8: A line that reaches 2^`CNT_W`-1 clocks invalidates the line length. Trailing edges are then ignored until the next complete line of normal length.
- R9: `field_odd_o` changes only together with `field_vld_o`, and each accepted trailing edge gives exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Path pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_ni | input | 1 | Horizontal sync, active low |
| vs_ni | input | 1 | Vertical sync, active low |
| field_odd_o | output | 1 | Held field parity, 1 = odd |
| field_vld_o | output | 1 | One-cycle strobe on each parity update |

## Verification
The bench builds two instances that share the same syncs. Both use `CNT_W` = 8 and `WIDE_THR` = 16; one has `WIDE_EN` = 1 and the other `WIDE_EN` = 0. The 8-bit counter brings the overlong-line case within reach in a few hundred cycles. A 40-clock line makes it practical to sweep every trailing-edge offset in the line, under a sync high time of 8 (half-line mode on both instances) and of 24 (sync-high mode on the main instance only). The expected parity is computed arithmetically from the offset, together with the short-pulse boundary at L = P-1 versus L = P.

// File: rtl/fpd_pkg.sv
package fpd_pkg;
  typedef enum logic {
    GEN_LINE_HALF = 1'b0,
    GEN_HS_HIGH   = 1'b1
  } gen_mode_e;
endpackage

// File: rtl/fpd_sync.sv
module fpd_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  // one extra stage holds the previous synchronised level
  logic [STAGES:0] sh_q;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[i] <= RST_VAL;
        else         sh_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[i] <= RST_VAL;
        else         sh_q[i] <= sh_q[i-1];
      end
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R2
endmodule

// File: rtl/fpd_line_timer.sv
module fpd_line_timer
  import fpd_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int WIDE_THR = 1024,
  parameter bit WIDE_EN  = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_lvl_i,
  input  logic             hs_rise_i,
  input  logic             hs_fall_i,
  output logic [CNT_W-1:0] line_len_o,
  output logic             line_ok_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, hcnt_q, line_len_q, high_len_q, hi_next;
  logic             line_ok_q, seen_fall_q, wide_hit;
  gen_mode_e        mode_q;

  assign hi_next = (hcnt_q == CNT_MAX) ? CNT_MAX : hcnt_q + CNT_ONE;

  if (WIDE_EN) begin : g_wide
    assign wide_hit = 32'(hi_next) >= WIDE_THR;
  end else begin : g_narrow
    assign wide_hit = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hcnt_q <= '0;
    end else begin
      if (hs_fall_i)            cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      if (hs_rise_i)            hcnt_q <= '0;
      else                      hcnt_q <= hi_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_fall_q <= 1'b0;
      line_ok_q   <= 1'b0;
      line_len_q  <= '0;
      high_len_q  <= '0;
      mode_q      <= GEN_LINE_HALF;
    end else if (hs_fall_i) begin
      seen_fall_q <= 1'b1;
      if (seen_fall_q && cnt_q != CNT_MAX) begin
        line_ok_q  <= 1'b1;
        line_len_q <= cnt_q + CNT_ONE;
        high_len_q <= hi_next;
        mode_q     <= wide_hit ? GEN_HS_HIGH : GEN_LINE_HALF;
      end else begin
        line_ok_q  <= 1'b0;
      end
    end else if (cnt_q == CNT_MAX) begin
      line_ok_q <= 1'b0;
    end
  end

  always_comb begin
    if (mode_q == GEN_HS_HIGH) pulse_o = line_ok_q && hs_lvl_i && (hcnt_q < (high_len_q >> 1));
    else                       pulse_o = line_ok_q && (cnt_q < (line_len_q >> 1));
  end

  assign line_len_o = line_len_q;
  assign line_ok_o  = line_ok_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_fall_i |=> (cnt_q == '0)); // R3
  AST_LONG_LINE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> !line_ok_q); // R8
  AST_FIRST_FALL_NO_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_fall_i && !seen_fall_q) |=> !line_ok_q); // R7
  if (!WIDE_EN) begin : g_chk_narrow
    AST_INSET_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q == GEN_LINE_HALF); // R5
  end
endmodule

// File: rtl/fpd_vs_qual.sv
module fpd_vs_qual #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vs_rise_i,
  input  logic             vs_fall_i,
  input  logic             pulse_i,
  input  logic             line_ok_i,
  input  logic [CNT_W-1:0] line_len_i,
  output logic             field_odd_o,
  output logic             field_vld_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] vcnt_q;
  logic [CNT_W:0]   vlen;
  logic             accept, odd_q, vld_q;

  // low time of vertical sync, inclusive of the current cycle
  assign vlen   = {1'b0, vcnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign accept = vs_rise_i && line_ok_i && (vlen >= {1'b0, line_len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q <= '0;
      odd_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (vs_fall_i)              vcnt_q <= '0;
      else if (vcnt_q != CNT_MAX) vcnt_q <= vcnt_q + CNT_ONE;
      vld_q <= accept;
      if (accept) odd_q <= pulse_i;
    end
  end

  assign field_odd_o = odd_q;
  assign field_vld_o = vld_q;

  AST_VLD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R9
  AST_ODD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_q |-> $stable(odd_q)); // R9
  AST_NEEDS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_ok_i |=> !vld_q); // R7
  AST_SHORT_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vs_rise_i && (vlen < {1'b0, line_len_i})) |=> !vld_q); // R6
endmodule

// File: rtl/field_parity_det.sv
module field_parity_det
  import fpd_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int WIDE_THR    = 1024,
  parameter bit WIDE_EN     = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_ni,
  input  logic vs_ni,
  output logic field_odd_o,
  output logic field_vld_o
);
  logic             hs_lvl, hs_rise, hs_fall;
  logic             vs_lvl, vs_rise, vs_fall;
  logic [CNT_W-1:0] line_len;
  logic             line_ok, pulse;

  fpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(hs_ni),
    .lvl_o(hs_lvl), .rise_o(hs_rise), .fall_o(hs_fall)
  );

  fpd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_vs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vs_ni),
    .lvl_o(vs_lvl), .rise_o(vs_rise), .fall_o(vs_fall)
  );

  fpd_line_timer #(.CNT_W(CNT_W), .WIDE_THR(WIDE_THR), .WIDE_EN(WIDE_EN)) u_line_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hs_lvl_i(hs_lvl), .hs_rise_i(hs_rise), .hs_fall_i(hs_fall),
    .line_len_o(line_len), .line_ok_o(line_ok), .pulse_o(pulse)
  );

  fpd_vs_qual #(.CNT_W(CNT_W)) u_vs_qual (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .vs_rise_i(vs_rise), .vs_fall_i(vs_fall),
    .pulse_i(pulse), .line_ok_i(line_ok), .line_len_i(line_len),
    .field_odd_o(field_odd_o), .field_vld_o(field_vld_o)
  );

  AST_VLD_AFTER_VS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_vld_o |-> $past(vs_lvl)); // R2
endmodule

// File: tb/field_parity_det_bench.sv
module field_parity_det_bench;
  localparam int CW  = 8;
  localparam int THR = 16;
  localparam int P   = 40;

  logic clk = 1'b0, rst_n = 1'b0, hs_n = 1'b1, vs_n = 1'b1;
  logic m_odd, m_vld, i_odd, i_vld;
  int   cyc = 0, n_chk = 0, n_fail = 0, rise_cyc = 0;
  int   m_cnt = 0, m_stamp = 0, i_cnt = 0, i_stamp = 0;
  logic m_cap = 1'b0, i_cap = 1'b0;
  bit   done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  field_parity_det #(.CNT_W(CW), .WIDE_THR(THR), .WIDE_EN(1'b1)) u_field_parity_det (
    .clk_i(clk), .rst_ni(rst_n), .hs_ni(hs_n), .vs_ni(vs_n),
    .field_odd_o(m_odd), .field_vld_o(m_vld));

  field_parity_det #(.CNT_W(CW), .WIDE_THR(THR), .WIDE_EN(1'b0)) u_inset (
    .clk_i(clk), .rst_ni(rst_n), .hs_ni(hs_n), .vs_ni(vs_n),
    .field_odd_o(i_odd), .field_vld_o(i_vld));

  always @(negedge clk) begin
    if (m_vld) begin m_cnt++; m_stamp = cyc; m_cap = m_odd; end
    if (i_vld) begin i_cnt++; i_stamp = cyc; i_cap = i_odd; end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // one line: hs low for len-hi clocks then high; optional vs edges at offsets
  task automatic line(input int len, input int hi, input int f, input int r);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      hs_n = (c < len - hi) ? 1'b0 : 1'b1;
      if (c == f) vs_n = 1'b0;
      if (c == r) begin vs_n = 1'b1; rise_cyc = cyc; end
    end
  endtask

  task automatic vec(input int hi, input int off);
    int  mc0, ic0;
    bit  e_main, e_ins;
    mc0 = m_cnt; ic0 = i_cnt;
    e_ins  = (off <= P / 2);
    e_main = (hi >= THR) ? ((off > P - hi) && (off - (P - hi) <= hi / 2)) : e_ins;
    line(P, hi, -1, -1);
    line(P, hi, 5, -1);
    line(P, hi, -1, -1);
    line(P, hi, -1, off);
    line(P, hi, -1, -1);
    check(m_cnt == mc0 + 1, "R9 one strobe", m_cnt - mc0, 1);
    check(m_stamp == rise_cyc + 3, "R2 strobe latency", m_stamp - rise_cyc, 3);
    if (hi >= THR) check(m_cap == e_main, "R4 sync-high parity", int'(m_cap), int'(e_main));
    else           check(m_cap == e_main, "R3 half-line parity", int'(m_cap), int'(e_main));
    check(i_cnt == ic0 + 1 && i_cap == e_ins, "R5 inset parity", int'(i_cap), int'(e_ins));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    int mc0, ic0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(m_odd == 1'b0 && m_vld == 1'b0, "R1 reset main", int'({m_odd, m_vld}), 0);
    check(i_odd == 1'b0 && i_vld == 1'b0, "R1 reset inset", int'({i_odd, i_vld}), 0);

    // R7: trailing edge before any complete line
    vs_n = 1'b0;
    repeat (60) @(negedge clk);
    line(P, 8, -1, 10);
    line(P, 8, -1, -1);
    check(m_cnt == 0 && i_cnt == 0, "R7 no line yet", m_cnt + i_cnt, 0);

    for (int off = 1; off < P; off++) vec(8, off);
    for (int off = 1; off < P; off++) vec(24, off);

    // R6: short pulse L = P-1 rejected, flag kept at 0
    mc0 = m_cnt; ic0 = i_cnt;
    line(P, 8, -1, -1);
    line(P, 8, 10, -1);
    line(P, 8, -1, 9);
    line(P, 8, -1, -1);
    check(m_cnt == mc0 && i_cnt == ic0, "R6 short pulse strobe", m_cnt - mc0, 0);
    check(m_odd == 1'b0 && i_odd == 1'b0, "R6 short pulse flag", int'(m_odd) + int'(i_odd), 0);

    // R6: L = P accepted, odd
    line(P, 8, 10, -1);
    line(P, 8, -1, 10);
    line(P, 8, -1, -1);
    check(m_cnt == mc0 + 1 && m_odd == 1'b1, "R6 exact line pulse", int'(m_odd), 1);
    check(i_cnt == ic0 + 1 && i_odd == 1'b1, "R6 exact line pulse inset", int'(i_odd), 1);

    // R8: overlong line invalidates, would-be even edge ignored
    mc0 = m_cnt; ic0 = i_cnt;
    line(300, 292, 100, -1);
    line(P, 8, -1, 30);
    line(P, 8, -1, -1);
    check(m_cnt == mc0 && i_cnt == ic0, "R8 overlong strobe", m_cnt - mc0, 0);
    check(m_odd == 1'b1 && i_odd == 1'b1, "R8 overlong flag", int'(m_odd) + int'(i_odd), 2);

    // R8: recovery after a complete normal line
    line(P, 8, 5, -1);
    line(P, 8, -1, -1);
    line(P, 8, -1, 30);
    line(P, 8, -1, -1);
    check(m_cnt == mc0 + 1 && m_odd == 1'b0, "R8 recovery", int'(m_odd), 0);
    check(i_cnt == ic0 + 1 && i_odd == 1'b0, "R8 recovery inset", int'(i_odd), 0);

    done = 1'b1;
    report();
  end
endmodule